// File: doc/BRIEF.md
# Hardware Breakpoint Trigger Register Set

This block holds the debug trigger registers of one hart. A small, parameterised number of triggers sits behind a select register. Each trigger has a 64-bit control word and a 64-bit compare word. A debugger reaches the three registers through a CSR access port keyed by the 12-bit CSR number. Reads return data combinationally in the same cycle. Writes take effect at the next clock edge.

Every register follows write-any-read-legal rules. A written value is stored in a legal form, and a later read returns that legal form. Only one trigger type is implemented: the address/data match type, used here for execute-address breakpoints with exact equality. Any other type field disables the trigger.

Writing zero to a control word always disables that trigger. In that state the compare word accepts and keeps any value. A debugger can therefore clear the control word, load the address, and then arm the trigger, without the address write being lost. The block compares each incoming instruction address against every armed trigger and raises a registered one-cycle hit pulse on a match.

Top module: `dbg_trig_unit`

## Requirements
- R1: The select register is CSR 0x7a0, the selected trigger's control word is CSR 0x7a1 and its compare word is CSR 0x7a2. Any other CSR number reads as 0, and a write to it changes no register.
- R2: After reset the select register is 0, every control word and every compare word is 0, and the hit output is low.
- R3: A select write with a value of NUM_TRIG or more stores NUM_TRIG-1. Smaller values are stored as written.
- R4: The trigger type is control bits 63:60. A control write whose type field is not 2 stores 0, which is a disabled trigger.
- R5: When a control write has type 2, bits 58:53 always read back as all ones, whatever was written there.
- R6: When a control write has type 2, bit 59 reads back exactly as written.
- R7: When a control write has type 2, the following bits are kept as written: bit 6, bits 4:0 (bit 2 is the execute enable), and the action field in bits 15:12 when it is 0 or 1. An action value above 1 reads back as 1. Every other bit reads back 0. For example, 0x280000000000105c reads back as 0x2fe000000000105c.
- R8: Writing 0 to a control word disables that trigger. The compare word then accepts any 64-bit value and reads it back unchanged.
- R9: A CSR write changes only the addressed register. Trigger registers change only for the trigger that is currently selected.
- R10: Take a cycle in which the address-valid input is high. If some trigger then has type 2, has its execute bit set, and has a compare word equal to the address, the hit output is high in the following cycle. The hit output is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrValid | input | 1 | CSR access strobe |
| csrWrite | input | 1 | 1 = write, 0 = read |
| csrAddr | input | 12 | CSR number |
| csrWdata | input | 64 | Write data |
| csrRdata | output | 64 | Read data (combinational) |
| pcValid | input | 1 | Instruction address valid |
| pc | input | 64 | Instruction address |
| hit | output | 1 | Breakpoint hit pulse, one cycle |

## Verification
The bench targets these corner cases, and the failure each one exposes:

- **Disable-then-load sequence.** Write 0 to the control word, load the compare word, then arm the trigger. A design that gates compare writes on an enabled trigger reads the address back as 0.
- **Over-range select.** Write a select value of NUM_TRIG or more. A design that truncates instead of clamping lands on the wrong trigger.
- **Legalised control fields.** Check the capability field, the kept bit 59, the clamped action field and the non-type-2 writes. Getting any of these wrong shows up as a wrong read-back value.
- **Isolation and hit behaviour.** Check that writes to one trigger leave the other unchanged. Check that the hit falls after one cycle, and stays low for a disarmed trigger or a disabled trigger with a matching address.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  localparam int XLEN = 64;
  localparam logic [11:0] CSR_SEL  = 12'h7a0;
  localparam logic [11:0] CSR_CTRL = 12'h7a1;
  localparam logic [11:0] CSR_CMP  = 12'h7a2;
  localparam logic [3:0]  TYPE_MATCH = 4'd2;

  typedef enum logic [1:0] {RD_NONE, RD_SEL, RD_CTRL, RD_CMP} rdSrc_e;

  typedef struct packed {
    logic   wrSel;
    logic   wrCtrl;
    logic   wrCmp;
    rdSrc_e rdSrc;
  } trigStrobe_t;

  // Map any written control value onto a supported configuration.
  function automatic logic [XLEN-1:0] legalCtrl(input logic [XLEN-1:0] w);
    logic [XLEN-1:0] r;
    r = '0;
    if (w[63:60] == TYPE_MATCH) begin
      r[63:60] = TYPE_MATCH;
      r[59]    = w[59];
      r[58:53] = 6'h3f;
      r[15:12] = (w[15:12] <= 4'd1) ? w[15:12] : 4'd1;
      r[6]     = w[6];
      r[4:0]   = w[4:0];
    end
    return r;
  endfunction

endpackage

// File: rtl/dbg_trig_ctrl.sv
module dbg_trig_ctrl
  import dbg_trig_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csrValid,
  input  logic        csrWrite,
  input  logic [11:0] csrAddr,
  output trigStrobe_t strobe
);

  logic isSel, isCtrl, isCmp;

  always_comb begin
    isSel  = (csrAddr == CSR_SEL);
    isCtrl = (csrAddr == CSR_CTRL);
    isCmp  = (csrAddr == CSR_CMP);
    strobe.wrSel  = csrValid && csrWrite && isSel;
    strobe.wrCtrl = csrValid && csrWrite && isCtrl;
    strobe.wrCmp  = csrValid && csrWrite && isCmp;
    if (isSel)       strobe.rdSrc = RD_SEL;
    else if (isCtrl) strobe.rdSrc = RD_CTRL;
    else if (isCmp)  strobe.rdSrc = RD_CMP;
    else             strobe.rdSrc = RD_NONE;
  end

  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrSel, strobe.wrCtrl, strobe.wrCmp}));

  // R1
  unknown_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSrc == RD_NONE) |-> !(strobe.wrSel || strobe.wrCtrl || strobe.wrCmp));

endmodule

// File: rtl/dbg_trig_dp.sv
module dbg_trig_dp
  import dbg_trig_pkg::*;
#(
  parameter int NUM_TRIG = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  trigStrobe_t     strobe,
  input  logic [XLEN-1:0] csrWdata,
  output logic [XLEN-1:0] csrRdata,
  input  logic            pcValid,
  input  logic [XLEN-1:0] pc,
  output logic            hit
);

  localparam int SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NUM_TRIG - 1);

  logic [SEL_W-1:0] selQ;
  logic [XLEN-1:0]  ctrlQ [NUM_TRIG];
  logic [XLEN-1:0]  cmpQ  [NUM_TRIG];
  logic             hitQ;
  logic [NUM_TRIG-1:0] armedMatch;

  // select register with clamp to the last implemented trigger
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0;
    end else if (strobe.wrSel) begin
      if (csrWdata >= XLEN'(NUM_TRIG)) selQ <= SEL_MAX;
      else                             selQ <= csrWdata[SEL_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlQ[i] <= '0;
        cmpQ[i]  <= '0;
      end else if (selQ == SEL_W'(i)) begin
        if (strobe.wrCtrl) ctrlQ[i] <= legalCtrl(csrWdata);
        if (strobe.wrCmp)  cmpQ[i]  <= csrWdata;
      end
    end

    assign armedMatch[i] = (ctrlQ[i][63:60] == TYPE_MATCH) && ctrlQ[i][2] &&
                           (cmpQ[i] == pc);

    // R4
    disabled_is_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlQ[i][63:60] != TYPE_MATCH) |-> (ctrlQ[i] == '0));

    // R5
    mask_field_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlQ[i][63:60] == TYPE_MATCH) |-> (ctrlQ[i][58:53] == 6'h3f));

    // R9
    untouched_trig_chk: assert property (@(posedge clk) disable iff (!rstN)
      (selQ != SEL_W'(i)) |=> ($stable(ctrlQ[i]) && $stable(cmpQ[i])));

    // R8
    zero_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrCtrl && selQ == SEL_W'(i) && csrWdata == '0) |=> (ctrlQ[i] == '0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) hitQ <= 1'b0;
    else       hitQ <= pcValid && (|armedMatch);
  end
  assign hit = hitQ;

  always_comb begin
    unique case (strobe.rdSrc)
      RD_SEL:  csrRdata = XLEN'(selQ);
      RD_CTRL: csrRdata = ctrlQ[selQ];
      RD_CMP:  csrRdata = cmpQ[selQ];
      default: csrRdata = '0;
    endcase
  end

  // R3
  sel_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    selQ <= SEL_MAX);

  // R10
  hit_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitQ |-> $past(pcValid));

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int NUM_TRIG = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csrValid,
  input  logic        csrWrite,
  input  logic [11:0] csrAddr,
  input  logic [63:0] csrWdata,
  output logic [63:0] csrRdata,
  input  logic        pcValid,
  input  logic [63:0] pc,
  output logic        hit
);

  trigStrobe_t strobe;

  dbg_trig_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csrValid (csrValid),
    .csrWrite (csrWrite),
    .csrAddr  (csrAddr),
    .strobe   (strobe)
  );

  dbg_trig_dp #(.NUM_TRIG(NUM_TRIG)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .csrWdata (csrWdata),
    .csrRdata (csrRdata),
    .pcValid  (pcValid),
    .pc       (pc),
    .hit      (hit)
  );

endmodule

// File: tb/dbg_trig_unit_tb.sv
module dbg_trig_unit_tb;

  typedef struct {
    logic [63:0] val;
    string       req;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrValid = 1'b0;
  logic        csrWrite = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [63:0] csrWdata = '0;
  logic [63:0] csrRdata;
  logic        pcValid = 1'b0;
  logic [63:0] pc = '0;
  logic        hit;

  int checks = 0;
  int fails = 0;
  expItem_t rdQ[$];
  expItem_t hitQ[$];
  logic pcPrev = 1'b0;

  always #10 clk = ~clk;

  dbg_trig_unit #(.NUM_TRIG(2)) u_dut (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrWrite(csrWrite),
    .csrAddr(csrAddr), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .pcValid(pcValid), .pc(pc), .hit(hit)
  );

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // driver tasks: inputs change 2 ns after a rising edge
  task automatic csrWr(input logic [11:0] a, input logic [63:0] d);
    @(posedge clk); #2;
    csrValid = 1'b1; csrWrite = 1'b1; csrAddr = a; csrWdata = d; pcValid = 1'b0;
  endtask

  task automatic csrRd(input logic [11:0] a, input logic [63:0] e, input string req);
    expItem_t it;
    @(posedge clk); #2;
    it.val = e; it.req = req;
    rdQ.push_back(it);
    csrValid = 1'b1; csrWrite = 1'b0; csrAddr = a; csrWdata = '0; pcValid = 1'b0;
  endtask

  task automatic pcStep(input logic [63:0] addr, input logic e, input string req);
    expItem_t it;
    @(posedge clk); #2;
    it.val = 64'(e); it.req = req;
    hitQ.push_back(it);
    csrValid = 1'b0; csrWrite = 1'b0; pcValid = 1'b1; pc = addr;
  endtask

  task automatic idle();
    @(posedge clk); #2;
    csrValid = 1'b0; csrWrite = 1'b0; pcValid = 1'b0;
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      if (csrValid && !csrWrite) begin
        expItem_t it;
        it = rdQ.pop_front();
        checks++;
        if (csrRdata !== it.val) begin
          fails++;
          $display("FAIL %s: read 0x%0h actual 0x%016h expected 0x%016h",
                   it.req, csrAddr, csrRdata, it.val);
        end
      end
      if (pcPrev) begin
        expItem_t it;
        it = hitQ.pop_front();
        checks++;
        if (hit !== it.val[0]) begin
          fails++;
          $display("FAIL %s: hit actual %0b expected %0b", it.req, hit, it.val[0]);
        end
      end
      pcPrev = pcValid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R2 reset state
    checks++;
    if (hit !== 1'b0) begin
      fails++;
      $display("FAIL R2: hit actual %0b expected 0", hit);
    end
    csrRd(12'h7a0, 64'h0, "R2");
    csrRd(12'h7a1, 64'h0, "R2");
    csrRd(12'h7a2, 64'h0, "R2");
    csrWr(12'h7a0, 64'd1);
    csrRd(12'h7a1, 64'h0, "R2");
    csrRd(12'h7a2, 64'h0, "R2");

    // R3 select clamp
    csrWr(12'h7a0, 64'd5);
    csrRd(12'h7a0, 64'd1, "R3");
    csrWr(12'h7a0, 64'hffff_ffff_ffff_fff0);
    csrRd(12'h7a0, 64'd1, "R3");
    csrWr(12'h7a0, 64'd0);
    csrRd(12'h7a0, 64'd0, "R3");

    // R7 R5 R6 legalisation of the type-2 control word
    csrWr(12'h7a1, 64'h2800_0000_0000_105c);
    csrRd(12'h7a1, 64'h2fe0_0000_0000_105c, "R7");
    csrWr(12'h7a1, 64'h2000_0000_0000_0004);
    csrRd(12'h7a1, 64'h27e0_0000_0000_0004, "R6");
    csrWr(12'h7a1, 64'h2000_0000_001f_ffa0);
    csrRd(12'h7a1, 64'h27e0_0000_0000_1000, "R7");
    csrWr(12'h7a1, 64'h2800_0000_0000_f004);
    csrRd(12'h7a1, 64'h2fe0_0000_0000_1004, "R5");

    // R4 other types disable
    csrWr(12'h7a1, 64'hffff_ffff_ffff_ffff);
    csrRd(12'h7a1, 64'h0, "R4");
    csrWr(12'h7a1, 64'h1000_0000_0000_0004);
    csrRd(12'h7a1, 64'h0, "R4");

    // R8 disable then load compare, then arm
    csrWr(12'h7a1, 64'h0);
    csrWr(12'h7a2, 64'h0000_0000_fc00_0000);
    csrRd(12'h7a2, 64'h0000_0000_fc00_0000, "R8");
    csrRd(12'h7a1, 64'h0, "R8");
    csrWr(12'h7a2, 64'hdead_beef_cafe_f00d);
    csrRd(12'h7a2, 64'hdead_beef_cafe_f00d, "R8");
    csrWr(12'h7a2, 64'h0000_0000_fc00_0000);

    // R9 isolation between triggers
    csrWr(12'h7a0, 64'd1);
    csrWr(12'h7a1, 64'h0);
    csrWr(12'h7a2, 64'h0000_0000_0000_1234);
    csrWr(12'h7a1, 64'h2000_0000_0000_0004);
    csrRd(12'h7a2, 64'h0000_0000_0000_1234, "R9");
    csrRd(12'h7a1, 64'h27e0_0000_0000_0004, "R9");
    csrWr(12'h7a0, 64'd0);
    csrRd(12'h7a1, 64'h0, "R9");
    csrRd(12'h7a2, 64'h0000_0000_fc00_0000, "R9");

    // R1 unknown CSR numbers
    csrWr(12'h7a3, 64'h5555_5555_5555_5555);
    csrWr(12'h7b0, 64'd1);
    csrRd(12'h7a3, 64'h0, "R1");
    csrRd(12'h7a0, 64'd0, "R1");
    csrRd(12'h7a1, 64'h0, "R1");
    csrRd(12'h7a2, 64'h0000_0000_fc00_0000, "R1");

    // R10 hit behaviour (trigger 1 armed at 0x1234, trigger 0 disabled)
    pcStep(64'h1234, 1'b1, "R10");
    pcStep(64'h1238, 1'b0, "R10");
    pcStep(64'h1234, 1'b1, "R10");
    pcStep(64'h1234, 1'b1, "R10");
    pcStep(64'hfc00_0000, 1'b0, "R10");
    idle();
    idle();
    checks++;
    if (hit !== 1'b0) begin
      fails++;
      $display("FAIL R10: hit without address actual %0b expected 0", hit);
    end
    csrWr(12'h7a0, 64'd1);
    csrWr(12'h7a1, 64'h2000_0000_0000_0040);
    pcStep(64'h1234, 1'b0, "R10");
    idle();
    idle();

    checks++;
    if (rdQ.size() != 0 || hitQ.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: pending actual %0d expected 0", rdQ.size() + hitQ.size());
    end
    report();
  end

endmodule